// File: doc/BRIEF.md
# Clock reference validity monitor

This block watches one reference clock, sampled by a faster system clock, and decides whether the reference can be trusted. It brings the reference into the system-clock domain and counts system-clock cycles between rising edges. Each measured period must lie inside a programmable inclusive range. A missing edge counts as a failure as soon as the count passes the upper bound, without waiting for the next edge.

When the nominal-rate selector names one of the two telecom rates (1.544 MHz or 2.048 MHz), the block also runs a second check. It measures the elapsed time of a programmable number of consecutive reference cycles and compares it with its own window. A typical setting is 64 cycles with a window of 62 to 66 nominal periods.

The block drives a valid flag and its complement, a fail flag. Both flags reflect signal quality only, and no switching policy outside the block affects them. A system with two references instantiates the block twice. After any failure, validity returns only once a full clean measurement has passed. With only the period check this is one period. With both checks it is one whole block of cycles. This hysteresis stops the flags from chattering.

Top module: `ref_validity_mon`

## Requirements
- R1: While rst_ni is low, and right after it is released, valid_o is 0 and fail_o is 1. All counters start from zero, and the first synchronized rising edge only arms the measurement.
- R2: fail_o is always the inverse of valid_o.
- R3: A period is the number of system-clock cycles between two successive synchronized rising edges of ref_i. A period below per_min_i or above per_max_i (bounds inclusive) clears valid_o on the next cycle.
- R4: If no rising edge arrives after an armed period count has reached per_max_i, valid_o is cleared, even though the edge never comes.
- R5: freq_sel_i encodes the nominal rate. 2'b01 (1.544 MHz) and 2'b10 (2.048 MHz) enable the block check. 2'b00 and 2'b11 (any other rate) disable it, and the block result is then ignored.
- R6: With the block check enabled, the span from a rising edge to the blk_n_i-th following rising edge is measured. A span outside [blk_min_i, blk_max_i] clears valid_o. So does a block still incomplete once its count reaches blk_max_i.
- R7: With the block check disabled, valid_o is set on the cycle after one in-range period measurement that coincides with no failure.
- R8: With the block check enabled, valid_o is set only after a block completes in its window, and no failure of either check may occur anywhere inside that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock under test (asynchronous) |
| freq_sel_i | input | 2 | Nominal rate code, see R5 |
| per_min_i | input | CNT_W | Shortest allowed period, in clock cycles |
| per_max_i | input | CNT_W | Longest allowed period, in clock cycles |
| blk_n_i | input | N_W | Reference cycles per block (at least 1) |
| blk_min_i | input | BLK_W | Shortest allowed block span, in clock cycles |
| blk_max_i | input | BLK_W | Longest allowed block span, in clock cycles |
| valid_o | output | 1 | Reference currently valid |
| fail_o | output | 1 | Reference currently invalid |

## Verification
The bench builds the block with CNT_W=6, BLK_W=8 and N_W=3 and uses four-cycle blocks. At these sizes every reference period from 3 to 14 clock cycles can be swept against the [6,10] range. Every pair of block-window bounds from 30 to 34 can be swept against a 32-cycle span, all within a few thousand cycles. The short blocks also make the recovery delay after a single bad period short enough to observe. The same holds for the effect of switching the rate code in both directions.

// File: rtl/ref_mon_pkg.sv
package ref_mon_pkg;
  typedef enum logic [1:0] {
    RATE_OTHER_A = 2'b00,
    RATE_1544K   = 2'b01,
    RATE_2048K   = 2'b10,
    RATE_OTHER_B = 2'b11
  } nom_rate_e;

  function automatic logic blk_check_en(logic [1:0] sel);
    return (sel == RATE_1544K) || (sel == RATE_2048K);
  endfunction
endpackage

// File: rtl/ref_mon_sync.sv
module ref_mon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ref_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ref_mon_period.sv
module ref_mon_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             meas_o,
  output logic [CNT_W-1:0] len_o,
  output logic             pass_o,
  output logic             fail_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             out_rng, timeout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (!(&cnt_q)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // saturating length: cycles since last edge, this one included
  assign len_o   = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
  assign meas_o  = rise_i & armed_q;
  assign out_rng = (len_o < min_i) || (len_o > max_i);
  assign timeout = armed_q && !rise_i && (cnt_q >= max_i);
  assign pass_o  = meas_o & ~out_rng;
  assign fail_o  = (meas_o & out_rng) | timeout;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ref_mon_block.sv
module ref_mon_block #(
  parameter int BLK_W = 20,
  parameter int N_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [N_W-1:0]   n_i,
  input  logic [BLK_W-1:0] min_i,
  input  logic [BLK_W-1:0] max_i,
  output logic             start_o,
  output logic             done_o,
  output logic [BLK_W-1:0] len_o,
  output logic             pass_o,
  output logic             fail_o
);
  logic [BLK_W-1:0] cyc_q;
  logic [N_W-1:0]   edge_q;
  logic             armed_q;
  logic             last, out_rng, timeout;
  logic [BLK_W-1:0] cyc_inc;

  assign last    = rise_i && armed_q &&
                   (({1'b0, edge_q} + {{N_W{1'b0}}, 1'b1}) == {1'b0, n_i});
  assign start_o = rise_i && (!armed_q || last);
  assign cyc_inc = (&cyc_q) ? cyc_q : cyc_q + BLK_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      edge_q  <= '0;
      armed_q <= 1'b0;
    end else if (start_o) begin
      cyc_q   <= '0;
      edge_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      cyc_q <= cyc_inc;
      if (rise_i) edge_q <= edge_q + N_W'(1);
    end
  end

  assign done_o  = last;
  assign len_o   = cyc_inc;
  assign out_rng = (len_o < min_i) || (len_o > max_i);
  assign timeout = armed_q && !last && (cyc_q >= max_i);
  assign pass_o  = last & ~out_rng;
  assign fail_o  = (last & out_rng) | timeout;
endmodule

// File: rtl/ref_validity_mon.sv
module ref_validity_mon
  import ref_mon_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BLK_W       = 20,
  parameter int N_W         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [1:0]       freq_sel_i,
  input  logic [CNT_W-1:0] per_min_i,
  input  logic [CNT_W-1:0] per_max_i,
  input  logic [N_W-1:0]   blk_n_i,
  input  logic [BLK_W-1:0] blk_min_i,
  input  logic [BLK_W-1:0] blk_max_i,
  output logic             valid_o,
  output logic             fail_o
);
  logic             rise_w;
  logic [CNT_W-1:0] per_cnt_w, per_len_w;
  logic             per_meas_w, per_pass, per_fail;
  logic             blk_start, blk_done_w, blk_pass, blk_fail;
  logic [BLK_W-1:0] blk_len_w;
  logic             blk_en, any_fail, set_valid;
  logic             valid_q, clean_q;

  ref_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ref_i, .rise_o(rise_w)
  );

  ref_mon_period #(.CNT_W(CNT_W)) u_per (
    .clk_i, .rst_ni, .rise_i(rise_w), .min_i(per_min_i), .max_i(per_max_i),
    .cnt_o(per_cnt_w), .meas_o(per_meas_w), .len_o(per_len_w),
    .pass_o(per_pass), .fail_o(per_fail)
  );

  ref_mon_block #(.BLK_W(BLK_W), .N_W(N_W)) u_blk (
    .clk_i, .rst_ni, .rise_i(rise_w), .n_i(blk_n_i),
    .min_i(blk_min_i), .max_i(blk_max_i),
    .start_o(blk_start), .done_o(blk_done_w), .len_o(blk_len_w),
    .pass_o(blk_pass), .fail_o(blk_fail)
  );

  assign blk_en    = blk_check_en(freq_sel_i);
  assign any_fail  = per_fail | (blk_en & blk_fail);
  assign set_valid = blk_en ? (blk_pass & clean_q) : per_pass;

  // clean_q: no failure since the current block began
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      if (any_fail)       valid_q <= 1'b0;
      else if (set_valid) valid_q <= 1'b1;
      if (any_fail)       clean_q <= 1'b0;
      else if (blk_start) clean_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign fail_o  = ~valid_q;
endmodule

// File: rtl/ref_validity_mon_chk.sv
module ref_validity_mon_chk
  import ref_mon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BLK_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       freq_sel_i,
  input logic [CNT_W-1:0] per_min_i,
  input logic [CNT_W-1:0] per_max_i,
  input logic [BLK_W-1:0] blk_min_i,
  input logic [BLK_W-1:0] blk_max_i,
  input logic             valid_o,
  input logic             fail_o,
  input logic             rise_w,
  input logic [CNT_W-1:0] per_cnt_w,
  input logic             per_meas_w,
  input logic [CNT_W-1:0] per_len_w,
  input logic             blk_done_w,
  input logic [BLK_W-1:0] blk_len_w
);
  logic en_w;
  assign en_w = blk_check_en(freq_sel_i);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_invalid_R1: assert (!valid_o && fail_o);
  end

  assert_period_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_meas_w && (per_len_w < per_min_i || per_len_w > per_max_i)) |=> !valid_o);

  assert_missing_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_w && per_cnt_w >= per_max_i) |=> !valid_o);

  assert_block_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && blk_done_w && (blk_len_w < blk_min_i || blk_len_w > blk_max_i)) |=> !valid_o);

  assert_valid_on_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rise_w));

  assert_block_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(valid_o) && $past(en_w)) |-> $past(blk_done_w));
endmodule

bind ref_validity_mon ref_validity_mon_chk #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .freq_sel_i(freq_sel_i),
  .per_min_i(per_min_i), .per_max_i(per_max_i),
  .blk_min_i(blk_min_i), .blk_max_i(blk_max_i),
  .valid_o(valid_o), .fail_o(fail_o), .rise_w(rise_w),
  .per_cnt_w(per_cnt_w), .per_meas_w(per_meas_w), .per_len_w(per_len_w),
  .blk_done_w(blk_done_w), .blk_len_w(blk_len_w)
);

// File: tb/sim_ref_validity_mon.sv
module sim_ref_validity_mon;
  localparam int CNT_W = 6;
  localparam int BLK_W = 8;
  localparam int N_W   = 3;
  localparam int TRAIN = 18;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ref_i = 1'b0;
  logic [1:0]       freq_sel_i = 2'b00;
  logic [CNT_W-1:0] per_min_i = 6'd6;
  logic [CNT_W-1:0] per_max_i = 6'd10;
  logic [N_W-1:0]   blk_n_i = 3'd4;
  logic [BLK_W-1:0] blk_min_i = 8'd30;
  logic [BLK_W-1:0] blk_max_i = 8'd34;
  logic             valid_o, fail_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  ref_validity_mon #(.CNT_W(CNT_W), .BLK_W(BLK_W), .N_W(N_W)) u0 (
    .clk_i, .rst_ni, .ref_i, .freq_sel_i, .per_min_i, .per_max_i,
    .blk_n_i, .blk_min_i, .blk_max_i, .valid_o, .fail_o
  );

  task automatic ref_cycles(input int hi, input int lo);
    repeat (hi) begin @(negedge clk_i); ref_i = 1'b1; end
    repeat (lo) begin @(negedge clk_i); ref_i = 1'b0; end
  endtask

  task automatic train(input int p, input int cnt);
    repeat (cnt) ref_cycles(p / 2, p - p / 2);
  endtask

  // every check also covers R2 (fail_o is the inverse of valid_o)
  task automatic chk(input string req, input logic exp_v);
    n_chk++;
    if (valid_o !== exp_v || fail_o !== ~exp_v) begin
      n_bad++;
      $display("FAIL %s R2: valid=%b fail=%b expected valid=%b fail=%b",
               req, valid_o, fail_o, exp_v, ~exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 after reset", 1'b0);

    // R3/R4/R7: period-only sweep, range [6,10]
    for (int p = 3; p <= 14; p++) begin
      train(p, TRAIN);
      chk($sformatf("R3 R4 R7 period=%0d", p), (p >= 6 && p <= 10));
    end

    // R4: edges stop entirely
    train(8, TRAIN);
    ref_cycles(0, 20);
    chk("R4 missing edge", 1'b0);

    // R5: period 7 passes period check, block span 28 misses [30,34]
    for (int f = 0; f < 4; f++) begin
      freq_sel_i = f[1:0];
      train(7, TRAIN);
      chk($sformatf("R5 freq_sel=%0d", f), (f == 0 || f == 3));
    end

    // R6: block mode period sweep, n=4, window [30,34]
    freq_sel_i = 2'b01;
    for (int p = 6; p <= 10; p++) begin
      train(p, TRAIN);
      chk($sformatf("R6 period=%0d span=%0d", p, 4 * p), (p == 8));
    end

    // R6: window bound sweep against span 32
    freq_sel_i = 2'b10;
    for (int lo = 30; lo <= 34; lo++) begin
      for (int hi = 30; hi <= 34; hi++) begin
        blk_min_i = BLK_W'(lo);
        blk_max_i = BLK_W'(hi);
        train(8, TRAIN);
        chk($sformatf("R6 window=[%0d,%0d]", lo, hi), (lo <= 32 && 32 <= hi));
      end
    end
    blk_min_i = 8'd30;
    blk_max_i = 8'd34;

    // R7: period-only recovery after one short period
    freq_sel_i = 2'b11;
    train(8, TRAIN);
    ref_cycles(1, 2);
    ref_cycles(4, 0);
    chk("R7 low after short period", 1'b0);
    ref_cycles(0, 4);
    ref_cycles(4, 0);
    chk("R7 restored after one good period", 1'b1);
    ref_cycles(0, 4);

    // R8: block recovery needs a full clean block
    freq_sel_i = 2'b01;
    train(8, TRAIN);
    chk("R8 valid before glitch", 1'b1);
    ref_cycles(1, 2);
    train(8, 2);
    chk("R8 still low two periods after glitch", 1'b0);
    train(8, 14);
    chk("R8 restored after clean block", 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule